// File: doc/BRIEF.md
# Cycle-Exact Command Sequencer

This block walks a byte-coded program held in a small instruction memory and runs each command in a fixed, known number of clock cycles. Each command's cycle count includes four cycles of fetch and decode. A family of idle commands adds zero to three extra cycles. Another family performs a counted wait in steps of three cycles. Together they let a program build any delay in single-cycle steps. Two commands drive an external latched output expander over an 8-bit bus with two strobes: an address strobe (`ale`) and a data-enable strobe (`dle`). One of these commands selects a port and writes it. The other rewrites the port that is already selected.

A pulse on `start` while the block is idle runs the program from address 0. The program ends with a halt byte. The memory read is combinational: `imem_data` must reflect `imem_addr` within the same cycle. The bus output register also serves as the shadow copy of the last byte driven.

Top module: `cyc_seq`

## Requirements
- R1: After reset `port_bus`=0x00, `ale`=0, `dle`=0, and `busy`, `done` and `err` are all 0.
- R2: A `start` pulse while idle clears `done` and `err` and begins at address 0. A `start` pulse while `busy` is high is ignored and does not change the program's timing.
- R3: Opcodes 0x00, 0x01, 0x02 and 0x03 are one byte long and last 4, 5, 6 and 7 cycles. Durations of consecutive commands add; for example 0x00 followed by 0x03 takes 11 cycles.
- R4: Opcodes 0x10, 0x11 and 0x12 are followed by a count byte n and last 7+3n, 8+3n and 9+3n cycles.
- R5: For the wait opcodes, a count byte of 0 is treated as n=256.
- R6: Opcode 0x20 is followed by an address byte and a data byte and lasts 20 cycles. Its bus actions come in this order: `dle` low, address on `port_bus`, `ale` high for exactly 2 cycles, `ale` low, data on `port_bus`, `dle` high. `ale` and `dle` are never high together.
- R7: Opcode 0x21 is followed by one data byte and lasts 7 cycles. It places the data on `port_bus` and leaves `dle` unchanged.
- R8: `port_bus` holds the last byte driven until another command drives it, and it does not change while the block is idle.
- R9: Any other opcode except 0xFF runs as a 1-byte, 4-cycle idle command and sets `err`. `err` stays set until the next accepted `start`.
- R10: Opcode 0xFF halts the program. `busy` falls and `done` rises together, C+1 clock edges after the edge that accepts `start`, where C is the summed duration of the commands before the halt. `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run the program from address 0 (taken only when idle) |
| imem_addr | output | AW | Instruction memory address |
| imem_data | input | 8 | Instruction memory byte at `imem_addr`, combinational |
| busy | output | 1 | Program running |
| done | output | 1 | Halt reached |
| err | output | 1 | Sticky flag: an unknown opcode was executed |
| port_bus | output | 8 | Expander bus; also the shadow of the last byte driven |
| ale | output | 1 | Expander address strobe |
| dle | output | 1 | Expander data-latch enable (transparent when high) |

## Verification
Two situations are hard to reach from the ports. The first is the count wrap, where a wait byte of zero must give the longest wait of 256 steps. The bench runs it with the slowest wait variant and times the `done` edge to the exact cycle (777 cycles). The second is a `start` pulse that arrives in the middle of a long wait. The bench injects one and confirms that the halt still lands on the cycle computed from the first start. The expander's ordering is checked by a behavioural latch model in the bench. That model would record a wrong port if the address were driven while `dle` was high, and it also shows that a data-only write made before any port was selected reaches no port.

// File: rtl/cyc_seq.sv
module cyc_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] imem_addr,
  input  logic [7:0]    imem_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    port_bus,
  output logic          ale,
  output logic          dle
);
  localparam int KW = $clog2(9 + 3 * 256);
  localparam logic [7:0] OP_PCH  = 8'h20;
  localparam logic [7:0] OP_PST  = 8'h21;
  localparam logic [7:0] OP_HALT = 8'hFF;

  logic [AW-1:0] pc;
  logic [KW-1:0] k, last;
  logic [7:0]    op, arg, arg2;
  logic [KW-1:0] nn;

  function automatic logic is_nop(input logic [7:0] o);
    return o[7:2] == 6'd0;
  endfunction
  function automatic logic is_wait(input logic [7:0] o);
    return o == 8'h10 || o == 8'h11 || o == 8'h12;
  endfunction
  function automatic logic [KW-1:0] first_last(input logic [7:0] o);
    if (is_nop(o))     return KW'(3) + KW'(o[1:0]);
    if (o == OP_PCH)   return KW'(19);
    if (o == OP_PST)   return KW'(6);
    if (is_wait(o))    return '1;
    return KW'(3);
  endfunction
  function automatic logic [AW-1:0] cmd_size(input logic [7:0] o);
    if (o == OP_PCH)              return AW'(3);
    if (o == OP_PST || is_wait(o)) return AW'(2);
    return AW'(1);
  endfunction

  assign busy      = run;
  assign imem_addr = pc + ((k == KW'(1)) ? AW'(1) : (k == KW'(2)) ? AW'(2) : AW'(0));
  assign nn        = (imem_data == 8'd0) ? KW'(256) : KW'(imem_data);

  logic run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; err <= 1'b0;
      pc <= '0; k <= '0; last <= '0;
      op <= '0; arg <= '0; arg2 <= '0;
      port_bus <= '0; ale <= 1'b0; dle <= 1'b0;
    end else if (!run) begin
      if (start) begin
        run <= 1'b1; pc <= '0; k <= '0; done <= 1'b0; err <= 1'b0;
      end
    end else begin
      k <= k + KW'(1);
      if (k == '0) begin
        op <= imem_data;
        if (imem_data == OP_HALT) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          last <= first_last(imem_data);
          if (!(is_nop(imem_data) || is_wait(imem_data) ||
                imem_data == OP_PCH || imem_data == OP_PST))
            err <= 1'b1;
        end
      end
      if (k == KW'(1)) begin
        arg <= imem_data;
        if (is_wait(op)) last <= KW'(6) + KW'(op[1:0]) + KW'(3) * nn;
      end
      if (k == KW'(2)) arg2 <= imem_data;
      if (op == OP_PCH && k != '0) begin
        case (k)
          KW'(4):  dle      <= 1'b0;
          KW'(6):  port_bus <= arg;
          KW'(7):  ale      <= 1'b1;
          KW'(9):  ale      <= 1'b0;
          KW'(11): port_bus <= arg2;
          KW'(12): dle      <= 1'b1;
          default: ;
        endcase
      end
      if (op == OP_PST && k == KW'(2)) port_bus <= arg;
      if (k != '0 && k == last) begin
        k  <= '0;
        pc <= pc + cmd_size(op);
      end
    end
  end
endmodule

module cyc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] port_bus,
  input logic       ale,
  input logic       dle
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !dle);
  p_ale_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  p_ale_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale && $past(ale) |=> !ale);
  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale && $past(ale) |-> $stable(port_bus));
  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(port_bus));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
endmodule

bind cyc_seq cyc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .port_bus(port_bus), .ale(ale), .dle(dle)
);

// File: tb/cyc_seq_test.sv
module cyc_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] imem_addr, imem_data, port_bus;
  logic busy, done, err, ale, dle;
  logic [7:0] mem [256];
  logic [7:0] xaddr;
  logic [7:0] xport [4];
  int nchk = 0, nerr = 0, ale_hi = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign imem_data = mem[imem_addr];

  cyc_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .imem_addr(imem_addr),
    .imem_data(imem_data), .busy(busy), .done(done), .err(err),
    .port_bus(port_bus), .ale(ale), .dle(dle));

  // behavioural expander: address latch plus transparent data latches
  always @(negedge clk) begin
    if (!rst_n) begin
      xaddr <= 8'h0;
      for (int i = 0; i < 4; i++) xport[i] <= 8'h0;
    end else begin
      if (ale) begin xaddr <= port_bus; ale_hi <= ale_hi + 1; end
      if (dle && xaddr < 8'd4) xport[xaddr[1:0]] <= port_bus;
    end
  end

  // op, arg1, arg2, cycles, err
  localparam logic [47:0] VEC [11] = '{
    {8'h00, 8'h00, 8'h00, 16'd4,   8'd0},
    {8'h01, 8'h00, 8'h00, 16'd5,   8'd0},
    {8'h02, 8'h00, 8'h00, 16'd6,   8'd0},
    {8'h03, 8'h00, 8'h00, 16'd7,   8'd0},
    {8'h10, 8'h01, 8'h00, 16'd10,  8'd0},
    {8'h11, 8'h02, 8'h00, 16'd14,  8'd0},
    {8'h12, 8'h00, 8'h00, 16'd777, 8'd0},
    {8'h10, 8'hFF, 8'h00, 16'd772, 8'd0},
    {8'h21, 8'h5A, 8'h00, 16'd7,   8'd0},
    {8'h20, 8'h01, 8'h99, 16'd20,  8'd0},
    {8'h42, 8'h00, 8'h00, 16'd4,   8'd1}
  };

  function automatic int sz(input logic [7:0] o);
    if (o == 8'h20) return 3;
    if (o == 8'h21 || o == 8'h10 || o == 8'h11 || o == 8'h12) return 2;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); cyc++;
      #1 if (done) return;
    end
    cyc = -1;
  endtask

  task automatic run(output int cyc);
    pulse_start();
    wait_done(cyc);
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 bus", port_bus, 0);
    chk("R1 strobes", {ale, dle}, 0);
    chk("R1 flags", {busy, done, err}, 0);
    rst_n = 1'b1;

    // data-only write before any port selected: bus changes, no port does
    put(0, 8'h21); put(1, 8'h77); put(2, 8'hFF);
    run(c);
    chk("R7 cycles", c, 8);
    chk("R7 bus", port_bus, 8'h77);
    chk("R7 dle kept low", dle, 0);
    chk("R7 no port written", {xport[0], xport[1], xport[2], xport[3]}, 0);

    for (int r = 0; r < 11; r++) begin
      logic [47:0] v;
      v = VEC[r];
      put(0, v[47:40]); put(1, v[39:32]); put(2, v[31:24]);
      put(sz(v[47:40]), 8'hFF);
      run(c);
      chk($sformatf("R3 R4 R5 R6 R7 R9 R10 row %0d cycles", r), c, int'(v[23:8]) + 1);
      chk($sformatf("R9 row %0d err", r), err, int'(v[7:0]));
      chk($sformatf("R10 row %0d busy", r), busy, 0);
      put(1, 8'hFF); put(2, 8'hFF);
    end

    // NOP then NOP3 = 11
    put(0, 8'h00); put(1, 8'h03); put(2, 8'hFF);
    run(c);
    chk("R3 sum", c, 12);

    // port select and write, then data-only rewrite of same port
    ale_hi = 0;
    put(0, 8'h20); put(1, 8'h02); put(2, 8'hA5); put(3, 8'hFF);
    run(c);
    chk("R6 cycles", c, 21);
    chk("R6 ale pulse width", ale_hi, 2);
    chk("R6 port2", xport[2], 8'hA5);
    chk("R6 port1 untouched", xport[1], 8'h99);
    chk("R6 dle high", dle, 1);
    chk("R8 shadow", port_bus, 8'hA5);
    repeat (5) @(negedge clk);
    chk("R8 idle hold", port_bus, 8'hA5);
    chk("R10 done held", done, 1);
    put(0, 8'h21); put(1, 8'h3C); put(2, 8'hFF); put(3, 8'hFF);
    run(c);
    chk("R7 rewrite port2", xport[2], 8'h3C);
    chk("R7 port1 still", xport[1], 8'h99);

    // err sticky across a later command, then cleared by start
    put(0, 8'h77); put(1, 8'h00); put(2, 8'hFF);
    run(c);
    chk("R9 sticky cycles", c, 9);
    chk("R9 sticky", err, 1);
    put(0, 8'h00); put(1, 8'hFF);
    pulse_start();
    #1 chk("R2 err cleared", err, 0);
    chk("R2 done cleared", done, 0);
    wait_done(c);

    // start during a wait is ignored
    put(0, 8'h10); put(1, 8'h0A); put(2, 8'hFF);
    pulse_start();
    c = 0;
    for (int i = 0; i < 5; i++) begin @(posedge clk); c++; end
    @(negedge clk) start = 1'b1;
    @(posedge clk); c++;
    @(negedge clk) start = 1'b0;
    begin
      int rest;
      wait_done(rest);
      chk("R2 ignored start", c + rest, 38);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule